// File: doc/BRIEF.md
# Timer Compare/Capture Channel

An up-counting timer with a single channel register that serves as either a match target or a snapshot store. In the two compare modes, the counter is checked against the channel value on every counting cycle. A hit raises an interrupt pulse and can optionally clear the counter, which sets the timer period. In the buffered variant, software writes go to a holding register. The live compare value only changes on defined reload events, and each reload also restarts the count from zero.

In the two capture modes, an external pin is brought into the clock domain by a synchroniser. The block watches it for transitions. On the chosen transition, or on either transition in dual-edge mode, the current count is latched into the channel register and an interrupt pulse is raised. A small word-addressed register port is used to write the control fields, write and read the channel value, and read the count.

Register port map (combinational read on `addr_i`, write on a clock edge with `req_i` and `we_i` high):

- word 0 is control:
  - bits [1:0] select the mode: 00 compare, 01 buffered compare, 10 single-edge capture, 11 dual-edge capture.
  - bit 2 enables clear-on-match.
  - bit 3 picks the buffered reload source: 0 reloads on overflow, 1 reloads on match.
  - bit 4 picks the capture edge: 0 rising, 1 falling.
  - bit 5 enables counting.
  - bit 6 is a write-only initialise strobe that reads as 0.
- word 1 is the channel register.
- word 2 returns the counter and is read-only.

Top module: `tmr_cc_chan`

## Requirements
- R1: After reset the channel register, the counter, the control word and `irq_o` are all zero.
- R2: In either compare mode with counting on, a cycle in which the count equals the live channel value is followed by `irq_o` high for exactly one cycle. Without clearing, the counter reads match+1 in that cycle.
- R3: With clear-on-match set (control bit 2), the counter returns to zero after a match, so interrupts repeat every channel value + 1 cycles.
- R4: Without clear-on-match, the counter wraps from all-ones to zero, so a compare interrupt repeats every 2^CNT_W cycles.
- R5: In buffered compare mode (mode 01), a channel write lands in the holding register. Reads of word 1 keep returning the live value until a reload.
- R6: Writing control bit 6 as 1 zeroes the counter. In buffered compare mode it also moves the holding value into the live register.
- R7: In buffered compare mode with control bit 3 at 0, a counter wrap from all-ones reloads the live value and leaves the counter at zero.
- R8: In buffered compare mode with control bit 3 at 1, a match reloads the live value and zeroes the counter.
- R9: When a channel write and a reload fall in the same cycle, the older holding value is transferred and the new write stays pending for the next reload.
- R10: In single-edge capture (mode 10), the edge picked by control bit 4 (0 rising, 1 falling) latches the count and pulses `irq_o`. The other edge changes neither.
- R11: In dual-edge capture (mode 11), both rising and falling edges latch the count and pulse `irq_o`.
- R12: `cap_i` passes two synchronising flops. For a pin change set up before clock edge e1, the count present between edges e2 and e3 is latched at e3, and `irq_o` is high between e3 and e4.
- R13: With control bit 5 at 0, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 2 | Register word select |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data, combinational on addr_i |
| cap_i | input | 1 | Asynchronous capture pin |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
A compare hit shows on `irq_o` one edge after the matching count. A capture pin change shows three edges after it is driven: two synchroniser flops, then the latch and interrupt register. The bench drives every stimulus at a falling clock edge and reads the count in that same half cycle. It then counts falling edges to the exact cycle where each result is due, so an expected capture value is the sampled count plus two. Reloads are checked by polling the counter until the cycle before the event. The coincident write is injected into that cycle, and the live value is read back on the following falling edge.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

  typedef enum logic [1:0] {
    MODE_CMP      = 2'b00,
    MODE_CMP_BUF  = 2'b01,
    MODE_CAP      = 2'b10,
    MODE_CAP_DUAL = 2'b11
  } cc_mode_e;

  typedef struct packed {
    logic     run;
    logic     fall_sel;
    logic     load_on_match;
    logic     clr_on_match;
    cc_mode_e mode;
  } cc_ctrl_t;

  localparam int unsigned CTRL_W   = 6;
  localparam int unsigned INIT_BIT = 6;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CHAN = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;

endpackage

// File: rtl/tmr_cc_edge.sv
module tmr_cc_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  // [STAGES-1] is the synchronised level, [STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];

endmodule

// File: rtl/tmr_cc_counter.sv
module tmr_cc_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         zero_i,
  input  logic         mclr_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);

  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;

  assign wrap_o = run_i && !mclr_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (zero_i)        cnt_q <= '0;
    else if (run_i) begin
      if (mclr_i)           cnt_q <= '0;
      else                  cnt_q <= cnt_q + CNT_ONE;
    end
  end

  assign cnt_o = cnt_q;

  // R6
  cnt_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |=> cnt_q == '0);
  // R4
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !zero_i && !mclr_i) |=> cnt_q == $past(cnt_q) + CNT_ONE);
  // R13
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !zero_i) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_cc_chreg.sv
module tmr_cc_chreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         buffered_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         load_i,
  input  logic         cap_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] live_o
);

  logic [W-1:0] live_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hold_q <= '0;
    else if (wr_i && buffered_i)  hold_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  live_q <= '0;
    else if (cap_i)               live_q <= cnt_i;
    else if (load_i)              live_q <= hold_q;
    else if (wr_i && !buffered_i) live_q <= wdata_i;
  end

  assign live_o = live_q;

  // R5
  buf_wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && buffered_i && !load_i && !cap_i) |=> $stable(live_q));
  // R9
  load_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !cap_i) |=> live_q == $past(hold_q));
  // R10
  cap_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> live_q == $past(cnt_i));

endmodule

// File: rtl/tmr_cc_chan.sv
module tmr_cc_chan
  import tmr_cc_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic             cap_i,
  output logic             irq_o
);

  cc_ctrl_t         ctrl_q;
  logic             wr_ctrl, wr_chan, init_stb;
  logic             is_cmp, is_buf, match, mclr, wrap, load_evt, zero_req;
  logic             rise, fall, cap_evt, irq_q;
  logic [CNT_W-1:0] cnt, live;

  assign wr_ctrl  = req_i && we_i && (addr_i == ADDR_CTRL);
  assign wr_chan  = req_i && we_i && (addr_i == ADDR_CHAN);
  assign init_stb = wr_ctrl && wdata_i[INIT_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= cc_ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  assign is_buf = (ctrl_q.mode == MODE_CMP_BUF);
  assign is_cmp = (ctrl_q.mode == MODE_CMP) || is_buf;
  assign match  = is_cmp && ctrl_q.run && (cnt == live);
  assign mclr   = match && ctrl_q.clr_on_match;

  // reload source picked by load_on_match; init always reloads
  assign load_evt = is_buf && (init_stb || (ctrl_q.load_on_match ? match : wrap));
  assign zero_req = init_stb || load_evt;

  always_comb begin
    unique case (ctrl_q.mode)
      MODE_CAP:      cap_evt = ctrl_q.fall_sel ? fall : rise;
      MODE_CAP_DUAL: cap_evt = rise || fall;
      default:       cap_evt = 1'b0;
    endcase
  end

  tmr_cc_edge #(.STAGES(SYNC_STG)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (cap_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  tmr_cc_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctrl_q.run),
    .zero_i (zero_req),
    .mclr_i (mclr),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  tmr_cc_chreg #(.W(CNT_W)) u_chreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .buffered_i (is_buf),
    .wr_i       (wr_chan),
    .wdata_i    (wdata_i),
    .load_i     (load_evt),
    .cap_i      (cap_evt),
    .cnt_i      (cnt),
    .live_o     (live)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= match || cap_evt;
  end

  assign irq_o = irq_q;

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = CNT_W'(ctrl_q);
      ADDR_CHAN: rdata_o = live;
      ADDR_CNT:  rdata_o = cnt;
      default:   rdata_o = '0;
    endcase
  end

  // R2
  cmp_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> irq_o);
  // R2
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(match || cap_evt));
  // R11
  cap_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> irq_o);
  // R8
  load_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_evt |=> rdata_o == '0 || addr_i != ADDR_CNT);

endmodule

// File: tb/tmr_cc_chan_tb_top.sv
module tmr_cc_chan_tb_top;

  localparam int unsigned W     = 8;
  localparam int unsigned CLK_P = 10;
  localparam int unsigned MASK  = (1 << W) - 1;

  localparam int unsigned C_CLR  = 4;
  localparam int unsigned C_LOM  = 8;
  localparam int unsigned C_FALL = 16;
  localparam int unsigned C_RUN  = 32;
  localparam int unsigned C_INIT = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0, cap = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr_cc_chan #(.CNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cap_i(cap), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = W'(d);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic wait_irq(input int lim, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < lim && !seen; i++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
  endtask

  task automatic cmp_period(input int n, input bit clr);
    int k, v;
    bit seen;
    wr(2'd0, 0);
    wr(2'd1, n);
    wr(2'd0, (clr ? C_CLR : 0) | C_RUN | C_INIT);
    wait_irq(600, seen);
    chk(seen, "R2 first compare irq", int'(seen), 1);
    rd(2'd2, v);
    if (!clr) chk(v == ((n + 1) & MASK), "R2 count after match", v, (n + 1) & MASK);
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 1) chk(!irq, "R2 single-cycle irq", int'(irq), 0);
    end while (!irq && k < 600);
    if (clr) chk(k == n + 1, "R3 period with clear", k, n + 1);
    else     chk(k == (1 << W), "R4 period with wrap", k, 1 << W);
  endtask

  task automatic cap_edge(input logic lvl, input bit exp_cap, input string tag);
    int c, prev, v;
    @(negedge clk);
    rd(2'd1, prev);
    rd(2'd2, c);
    cap = lvl;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(!irq, {tag, " no early irq"}, int'(irq), 0);
    end
    @(negedge clk);
    rd(2'd1, v);
    if (exp_cap) begin
      chk(irq, {tag, " R12 irq due"}, int'(irq), 1);
      chk(v == ((c + 2) & MASK), {tag, " R12 captured count"}, v, (c + 2) & MASK);
      @(negedge clk);
      chk(!irq, {tag, " irq one cycle"}, int'(irq), 0);
    end else begin
      chk(!irq, {tag, " ignored edge irq"}, int'(irq), 0);
      chk(v == prev, {tag, " ignored edge value"}, v, prev);
      @(negedge clk);
      chk(!irq, {tag, " ignored edge late irq"}, int'(irq), 0);
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v, c;
    bit seen, hit;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk(v == 0, "R1 ctrl reset", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 chan reset", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 cnt reset", v, 0);
    chk(!irq, "R1 irq reset", int'(irq), 0);

    // R13 hold with run low
    repeat (10) @(negedge clk);
    rd(2'd2, v); chk(v == 0, "R13 counter held", v, 0);

    // R2 R3 sweep over compare values with clear
    for (int n = 1; n < 48; n++) cmp_period(n, 1'b1);
    for (int n = 240; n <= 255; n++) cmp_period(n, 1'b1);
    // R4 wrap period
    cmp_period(77, 1'b0);
    cmp_period(3, 1'b0);

    // R13 stop mid count
    wr(2'd0, 0);
    rd(2'd2, c);
    repeat (7) @(negedge clk);
    rd(2'd2, v); chk(v == c, "R13 counter stopped", v, c);

    // buffered compare, reload on overflow
    wr(2'd0, 1);
    wr(2'd1, 10);
    rd(2'd1, v); chk(v == 3, "R5 read shows live value", v, 3);
    wr(2'd0, 1 | C_RUN | C_INIT);
    rd(2'd2, v); chk(v == 0, "R6 init zeroes counter", v, 0);
    rd(2'd1, v); chk(v == 10, "R6 init reloads", v, 10);
    wr(2'd1, 20);
    rd(2'd1, v); chk(v == 10, "R5 buffered write pending", v, 10);
    wait_irq(600, seen);
    rd(2'd2, v); chk(v == 11, "R2 buffered match count", v, 11);
    rd(2'd1, v); chk(v == 10, "R5 still pending after match", v, 10);
    c = 11;
    hit = 1'b0;
    for (int i = 0; i < 600 && !hit; i++) begin
      @(negedge clk);
      rd(2'd2, v);
      if (v < c) hit = 1'b1;
      c = v;
    end
    chk(c == 0, "R7 counter zero after wrap", c, 0);
    rd(2'd1, v); chk(v == 20, "R7 reload on overflow", v, 20);
    wait_irq(600, seen);
    rd(2'd2, v); chk(v == 21, "R7 new compare value used", v, 21);

    // buffered compare, reload on match
    wr(2'd1, 30);
    wr(2'd0, 1 | C_LOM | C_RUN);
    wait_irq(600, seen);
    rd(2'd2, v); chk(v == 0, "R8 match zeroes counter", v, 0);
    rd(2'd1, v); chk(v == 30, "R8 reload on match", v, 30);

    // R9 write coinciding with reload
    wr(2'd1, 50);
    hit = 1'b0;
    for (int i = 0; i < 600 && !hit; i++) begin
      @(negedge clk);
      rd(2'd2, v);
      if (v == 30) begin
        hit = 1'b1;
        req = 1'b1; we = 1'b1; addr = 2'd1; wdata = W'(70);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
      end
    end
    rd(2'd1, v); chk(v == 50, "R9 older buffer transferred", v, 50);
    @(negedge clk);
    wait_irq(600, seen);
    rd(2'd1, v); chk(v == 70, "R9 new write applied next reload", v, 70);

    // capture, rising edge
    wr(2'd0, 2 | C_RUN);
    for (int i = 0; i < 6; i++) begin
      repeat (i * 11) @(negedge clk);
      cap_edge(1'b1, 1'b1, "R10 rising");
      cap_edge(1'b0, 1'b0, "R10 falling ignored");
    end
    // capture, falling edge
    wr(2'd0, 2 | C_FALL | C_RUN);
    for (int i = 0; i < 6; i++) begin
      repeat (i * 13) @(negedge clk);
      cap_edge(1'b1, 1'b0, "R10 rising ignored");
      cap_edge(1'b0, 1'b1, "R10 falling");
    end
    // dual edge
    wr(2'd0, 3 | C_RUN);
    for (int i = 0; i < 6; i++) begin
      repeat (i * 5) @(negedge clk);
      cap_edge(1'b1, 1'b1, "R11 rising");
      cap_edge(1'b0, 1'b1, "R11 falling");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule